// File: doc/BRIEF.md
# Four-Mode Addressable Sink-Output Latch

This block keeps eight single-bit latches that drive eight low-side sink-enable outputs. A 3-bit select, one data bit, an active-low enable and an active-low clear are sampled on each rising edge of the system clock. The clear and enable levels together pick one of four modes for that cycle:

- a write of the data bit into one latch;
- holding every latch;
- a one-of-eight decode in which only the addressed output may be on;
- a forced clear of every latch.

The stored vector is registered and drives the outputs directly. A 1 on `sink_on` means that stage pulls its pin low. `pin_lvl` gives the resulting pin level, which is the inverse of `sink_on`.

A one-cycle flag, `sel_hazard`, reports a select change made while enable is active. A user should move the select only while enable is inactive, because an active enable writes to whichever latch the select points at.

Top module: `addr_sink_latch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sink_on` becomes all zeros and `sel_hazard` becomes 0 after that edge. The last-sampled select is also reset to 0.
- R2: At an edge with `clr_n`=1 and `en_n`=0, bit `sel` of `sink_on` takes `din`, and the other seven bits keep their values.
- R3: `sel` is plain binary with `sel[2]` as the most significant bit. Value 0 addresses `sink_on[0]` and value 7 addresses `sink_on[7]`.
- R4: At an edge with `clr_n`=1 and `en_n`=1, `sink_on` keeps its value whatever `sel` and `din` are.
- R5: At an edge with `clr_n`=0 and `en_n`=0, `sink_on` becomes `din` at bit `sel` and 0 at every other bit. A later hold keeps that pattern.
- R6: At an edge with `clr_n`=0 and `en_n`=1, `sink_on` becomes all zeros whatever `sel` and `din` are.
- R7: `pin_lvl` is always the bitwise inverse of `sink_on`.
- R8: After an edge where `en_n`=0 and `sel` differs from the select sampled at the previous edge, `sel_hazard` is 1 for one cycle; after any other edge it is 0. The write of R2 or R5 still takes place.
- R9: Every output changes only at a rising clock edge, one register after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 3 | Latch address |
| din | input | 1 | Data bit |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| sink_on | output | 8 | 1 = output stage sinking current |
| pin_lvl | output | 8 | Pin level, inverse of `sink_on` |
| sel_hazard | output | 1 | Select changed while enable was active |

## Verification
The hardest case to reach is the interplay between the last-sampled select and the mode sequence. The hazard flag depends on the select seen at the previous edge, whatever mode that edge was in. The stimulus therefore changes the address first in a hold cycle and then enables, which must not raise the flag. It also changes the address directly during a write, which must raise the flag while still performing the write. A decode followed by a hold, and a mid-run reset that resets the remembered select, close the sequence.

// File: rtl/addr_sink_latch.sv
module addr_sink_latch #(
  parameter int WIDTH = 8,
  localparam int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  input  logic             en_n,
  input  logic             clr_n,
  output logic [WIDTH-1:0] sink_on,
  output logic [WIDTH-1:0] pin_lvl,
  output logic             sel_hazard
);

  logic [WIDTH-1:0] state_q, state_d, addr_dec;
  logic [SEL_W-1:0] sel_q;
  logic             haz_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_dec
    assign addr_dec[i] = (sel == SEL_W'(i));
  end

  always_comb begin
    unique case ({clr_n, en_n})
      2'b10:   state_d = (state_q & ~addr_dec) | (addr_dec & {WIDTH{din}});
      2'b11:   state_d = state_q;
      2'b00:   state_d = addr_dec & {WIDTH{din}};
      default: state_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      sel_q   <= '0;
      haz_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel;
      haz_q   <= !en_n && (sel != sel_q);
    end
  end

  assign sink_on    = state_q;
  assign pin_lvl    = ~state_q;
  assign sel_hazard = haz_q;

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && en_n) |=> (sink_on == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && en_n) |=> $stable(sink_on));

  p_demux_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !en_n) |=> $onehot0(sink_on));

  p_latch_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !en_n) |=> (((sink_on ^ $past(sink_on)) & ~$past(addr_dec)) == '0));

  p_latch_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !en_n) |=> (sink_on[$past(sel)] == $past(din)));

  p_no_haz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !sel_hazard);

  p_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl ^ sink_on) == '1);

endmodule

// File: tb/addr_sink_latch_tb.sv
module addr_sink_latch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = '0;
  logic       din = 1'b0;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [7:0] sink_on, pin_lvl;
  logic       sel_hazard;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] m_state = '0;
  logic [2:0] m_sel   = '0;
  logic [7:0] q_sink[$];
  logic       q_haz[$];
  string      q_tag[$];

  addr_sink_latch u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .din(din), .en_n(en_n), .clr_n(clr_n),
    .sink_on(sink_on), .pin_lvl(pin_lvl), .sel_hazard(sel_hazard)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic r, input logic c, input logic e,
                      input logic [2:0] s, input logic d, input string tag);
    logic h;
    @(negedge clk);
    rst_n = r; clr_n = c; en_n = e; sel = s; din = d;
    if (!r) begin
      m_state = '0; m_sel = '0; h = 1'b0;
    end else begin
      h = !e && (s != m_sel);
      m_sel = s;
      case ({c, e})
        2'b10: m_state[s] = d;
        2'b11: ;
        2'b00: begin m_state = '0; m_state[s] = d; end
        default: m_state = '0;
      endcase
    end
    q_sink.push_back(m_state);
    q_haz.push_back(h);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q_sink.size() > 0) begin
      logic [7:0] es;
      logic eh;
      string t;
      es = q_sink.pop_front(); eh = q_haz.pop_front(); t = q_tag.pop_front();
      n_tests++;
      if (sink_on !== es) begin
        n_fail++;
        $display("FAIL %s sink_on actual=%b expected=%b", t, sink_on, es);
      end
      n_tests++;
      if (pin_lvl !== ~es) begin
        n_fail++;
        $display("FAIL R7 (%s) pin_lvl actual=%b expected=%b", t, pin_lvl, ~es);
      end
      n_tests++;
      if (sel_hazard !== eh) begin
        n_fail++;
        $display("FAIL R8 (%s) sel_hazard actual=%b expected=%b", t, sel_hazard, eh);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(0, 1, 1, 3'd5, 1, "R1 reset");
    step(0, 0, 0, 3'd2, 1, "R1 reset");
    // R2 R3: proper protocol, address set while holding, then write
    for (int k = 0; k < 8; k++) begin
      step(1, 1, 1, 3'(k), 1'b0, "R4 hold addr move");
      step(1, 1, 0, 3'(k), k[0], "R2 R3 write");
    end
    // R4: hold ignores sel and din
    for (int k = 0; k < 8; k++) step(1, 1, 1, 3'(7 - k), k[1], "R4 hold");
    // R8: select changes under active enable, write still happens
    step(1, 1, 0, 3'd3, 1, "R8 R2 hazard write");
    step(1, 1, 0, 3'd6, 1, "R8 R2 hazard write");
    step(1, 1, 0, 3'd6, 0, "R2 same addr no hazard");
    // R5: decode each address, then data low
    for (int k = 0; k < 8; k++) step(1, 0, 0, 3'(k), 1'b1, "R5 R3 demux");
    step(1, 0, 0, 3'd4, 0, "R5 demux data low");
    step(1, 0, 0, 3'd1, 1, "R5 demux");
    step(1, 1, 1, 3'd7, 0, "R5 R4 hold after demux");
    step(1, 1, 1, 3'd0, 1, "R5 R4 hold after demux");
    // R6: clear ignores sel and din
    step(1, 1, 0, 3'd0, 1, "R2 write before clear");
    step(1, 0, 1, 3'd7, 1, "R6 clear");
    step(1, 0, 1, 3'd2, 0, "R6 clear");
    // R1: mid-run reset then remembered select is 0
    step(1, 1, 0, 3'd5, 1, "R2 write");
    step(0, 1, 0, 3'd5, 1, "R1 mid reset");
    step(1, 1, 0, 3'd0, 1, "R1 R8 sel after reset");
    step(1, 1, 0, 3'd7, 1, "R9 R8 write");
    step(1, 1, 1, 3'd7, 0, "R9 hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule